// File: doc/BRIEF.md
# Trainer System Address Decoder and I/O Port

This block is the address glue for a small 8-bit trainer computer whose processor drives only twelve address lines. When the processor pulses its address strobe, the block takes the four high address bits from the upper half of the data bus and keeps them. With those bits and the twelve live address lines, it decodes every read and write. The 4 KB map holds two 1 KB ROM selects, eight 128-byte RAM bank selects, a read-only port for eight toggle switches, and an 8-bit output register that drives LEDs. Writes that land in the ROM window load that register.

The chip selects, the read-data multiplexer and the data-bus output enable are combinational. They are built from the live address, the read and write strobes (active-low levels) and the stored high nibble. The high nibble and the LED register change only on the rising system clock edge. A parameter sets how the high nibble is used. With zero-page qualification on, only the bottom 4 KB of the 64 KB space is decoded. With it off, the 4 KB map repeats sixteen times. The ROM and RAM arrays sit outside the block. Only their selects and data inputs come in here.

Top module: `trainer_bus_decoder`

## Requirements
- R1: On each rising clock edge where `adr_strobe_n` is low, `addr_hi` loads `db_in[7:4]`. Otherwise `addr_hi` holds its value. Reset sets it to 0.
- R2: A read (`rd_n`=0, `wr_n`=1) with address bits [11:10]=00 drives `rom_sel_n[0]` low. With [11:10]=01 it drives `rom_sel_n[1]` low. In both cases `db_out` equals `rom_data`.
- R3: A read or write with address bits [11:10]=11 drives exactly one bit of `ram_sel_n` low: the bit indexed by address bits [9:7]. On a read, `db_out` equals `ram_data`.
- R4: A read with address bits [11:10]=10 places `sw_in` on `db_out` and asserts no chip select.
- R5: A write (`wr_n`=0, `rd_n`=1) with address bit 11 = 0 loads `db_in` into `led_out` on the next rising edge. A write with [11:10]=10 changes nothing.
- R6: `led_out` is 0x00 after reset. Reads, idle cycles and undecoded writes leave it unchanged.
- R7: With `ZERO_PAGE_EN`=1, nothing is decoded unless `addr_hi` is 0. With `ZERO_PAGE_EN`=0, the map is decoded the same way for every `addr_hi` value.
- R8: At most one select (ROM, RAM bank, switch read, LED load) is active at a time. None is active while both strobes are high or while both strobes are low.
- R9: `db_oe` is 1 only during a decoded read (ROM, RAM or switch). Whenever `db_oe` is 0, `db_out` is 0x00.
- R10: An access in the same cycle as an address-strobe capture is decoded with the `addr_hi` value held before that edge. The new value applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_lo | input | 12 | Live address lines A11..A0 |
| adr_strobe_n | input | 1 | Active-low address strobe; high nibble is taken from the data bus |
| rd_n | input | 1 | Active-low read strobe (level) |
| wr_n | input | 1 | Active-low write strobe (level) |
| db_in | input | 8 | Data bus from the processor |
| sw_in | input | 8 | Toggle-switch inputs |
| rom_data | input | 8 | Read data from the selected ROM |
| ram_data | input | 8 | Read data from the selected RAM bank |
| rom_sel_n | output | 2 | Active-low ROM selects |
| ram_sel_n | output | 8 | Active-low RAM bank selects |
| addr_hi | output | 4 | Stored address bits A15..A12 |
| led_out | output | 8 | LED output register |
| db_out | output | 8 | Read data toward the processor |
| db_oe | output | 1 | Data-bus output enable for a decoded read |

## Verification
Two functions can act on the same clock edge: capturing a new high nibble on the address strobe, and decoding a write that loads the LED register. The bench forces this overlap on a zero-page build. It holds the address strobe low during an LED write whose data carries a nonzero upper nibble. The write must still land, because it is judged against the nibble held before the edge. A second write one cycle later must be rejected, because it sees the new nibble. Around that case, every high-nibble value is swept against addresses across all four regions and four strobe combinations. The zero-page build and the mirrored build are checked side by side against an arithmetic model.

// File: rtl/trainer_bus_pkg.sv
package trainer_bus_pkg;

   // Region of the 4 KB page, taken from address bits 11:10.
   typedef enum logic [1:0] {
      REG_ROM0   = 2'b00,
      REG_ROM1   = 2'b01,
      REG_SWITCH = 2'b10,
      REG_RAM    = 2'b11
   } region_e;

   // Kind of bus cycle, derived from the two strobe levels.
   typedef enum logic [1:0] {
      CYC_IDLE  = 2'b00,
      CYC_READ  = 2'b01,
      CYC_WRITE = 2'b10,
      CYC_CLASH = 2'b11
   } cycle_e;

   function automatic cycle_e cycle_of(input logic rd_n, input logic wr_n);
      cycle_e c;
      c = cycle_e'({~wr_n, ~rd_n});
      return c;
   endfunction

   function automatic logic is_rom_window(input region_e r);
      return (r == REG_ROM0) || (r == REG_ROM1);
   endfunction

endpackage

// File: rtl/trainer_hi_latch.sv
module trainer_hi_latch #(
   parameter int HI_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            adr_strobe_n,
   input  logic [HI_W-1:0] db_hi,
   output logic [HI_W-1:0] addr_hi
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr_hi <= '0;
      else if (!adr_strobe_n)
         addr_hi <= db_hi;
   end

   // R1: the strobe edge captures the upper data bits
   a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
      !adr_strobe_n |=> addr_hi == $past(db_hi));

   // R1: without the strobe the nibble is held
   a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
      adr_strobe_n |=> $stable(addr_hi));

endmodule

// File: rtl/trainer_addr_decode.sv
module trainer_addr_decode
   import trainer_bus_pkg::*;
#(
   parameter int RAM_BANKS    = 8,
   parameter int HI_W         = 4,
   parameter bit ZERO_PAGE_EN = 1'b1,
   localparam int BANK_W      = $clog2(RAM_BANKS),
   localparam int TOP_W       = 2 + BANK_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [TOP_W-1:0]     addr_top,
   input  logic [HI_W-1:0]      addr_hi,
   input  logic                 rd_n,
   input  logic                 wr_n,
   output logic [1:0]           rom_sel_n,
   output logic [RAM_BANKS-1:0] ram_sel_n,
   output logic                 ram_rd,
   output logic                 sw_rd,
   output logic                 led_wr
);

   region_e            region;
   cycle_e             cyc;
   logic [BANK_W-1:0]  bank;
   logic               zp_ok;
   logic               rd_ok;
   logic               wr_ok;
   logic               ram_hit;

   assign region = region_e'(addr_top[TOP_W-1 -: 2]);
   assign bank   = addr_top[BANK_W-1:0];
   assign cyc    = cycle_of(rd_n, wr_n);

   // Zero-page qualification or full mirroring, chosen at elaboration.
   generate
      if (ZERO_PAGE_EN) begin : g_zero_page
         assign zp_ok = (addr_hi == '0);
      end else begin : g_mirror
         logic hi_unused;
         assign hi_unused = ^addr_hi;
         assign zp_ok     = 1'b1;
      end
   endgenerate

   assign rd_ok = (cyc == CYC_READ)  && zp_ok;
   assign wr_ok = (cyc == CYC_WRITE) && zp_ok;

   generate
      for (genvar gi = 0; gi < 2; gi++) begin : g_rom
         assign rom_sel_n[gi] = ~(rd_ok && (region == region_e'(2'(gi))));
      end
   endgenerate

   assign ram_hit = (rd_ok || wr_ok) && (region == REG_RAM);
   assign ram_rd  = rd_ok && (region == REG_RAM);

   generate
      for (genvar gb = 0; gb < RAM_BANKS; gb++) begin : g_bank
         assign ram_sel_n[gb] = ~(ram_hit && (bank == BANK_W'(gb)));
      end
   endgenerate

   assign sw_rd  = rd_ok && (region == REG_SWITCH);
   assign led_wr = wr_ok && is_rom_window(region);

   // R8: never two selects at once
   a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({~rom_sel_n, ~ram_sel_n, sw_rd, led_wr}));

   // R8: both strobes idle means nothing selected
   a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_n && wr_n) |-> (&rom_sel_n && &ram_sel_n && !sw_rd && !led_wr));

   // R8: both strobes low is not an access
   a_r8_clash: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n && !wr_n) |-> (&rom_sel_n && &ram_sel_n && !sw_rd && !led_wr));

   // R2: a ROM select needs a pure read
   a_r2_rom_read: assert property (@(posedge clk) disable iff (!rst_n)
      !(&rom_sel_n) |-> (!rd_n && wr_n));

   // R7: outside page zero nothing decodes when qualification is on
   a_r7_zero_page: assert property (@(posedge clk) disable iff (!rst_n)
      (ZERO_PAGE_EN && addr_hi != '0) |->
         (&rom_sel_n && &ram_sel_n && !sw_rd && !led_wr));

endmodule

// File: rtl/trainer_out_latch.sv
module trainer_out_latch #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              led_wr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] led
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         led <= '0;
      else if (led_wr)
         led <= din;
   end

   // R5: a decoded write lands on the next edge
   a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
      led_wr |=> led == $past(din));

   // R6: nothing else disturbs the register
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !led_wr |=> $stable(led));

endmodule

// File: rtl/trainer_rdata_mux.sv
module trainer_rdata_mux #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_n,
   input  logic              rom_rd,
   input  logic              ram_rd,
   input  logic              sw_rd,
   input  logic [DATA_W-1:0] rom_data,
   input  logic [DATA_W-1:0] ram_data,
   input  logic [DATA_W-1:0] sw_in,
   output logic [DATA_W-1:0] db_out,
   output logic              db_oe
);

   always_comb begin
      db_out = '0;
      if (rom_rd)
         db_out = rom_data;
      else if (ram_rd)
         db_out = ram_data;
      else if (sw_rd)
         db_out = sw_in;
   end

   assign db_oe = rom_rd | ram_rd | sw_rd;

   // R9: the bus is driven only during a read
   a_r9_oe_read: assert property (@(posedge clk) disable iff (!rst_n)
      db_oe |-> !rd_n);

   // R9: undriven bus reads as zero
   a_r9_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !db_oe |-> db_out == '0);

   // R8: a single read source at a time
   a_r8_one_source: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rom_rd, ram_rd, sw_rd}));

endmodule

// File: rtl/trainer_bus_decoder.sv
module trainer_bus_decoder
   import trainer_bus_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int ADDR_LO_W    = 12,
   parameter int HI_W         = 4,
   parameter int RAM_BANKS    = 8,
   parameter bit ZERO_PAGE_EN = 1'b1,
   localparam int BANK_W      = $clog2(RAM_BANKS),
   localparam int TOP_W       = 2 + BANK_W,
   localparam int LOW_W       = ADDR_LO_W - TOP_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_LO_W-1:0] addr_lo,
   input  logic                 adr_strobe_n,
   input  logic                 rd_n,
   input  logic                 wr_n,
   input  logic [DATA_W-1:0]    db_in,
   input  logic [DATA_W-1:0]    sw_in,
   input  logic [DATA_W-1:0]    rom_data,
   input  logic [DATA_W-1:0]    ram_data,
   output logic [1:0]           rom_sel_n,
   output logic [RAM_BANKS-1:0] ram_sel_n,
   output logic [HI_W-1:0]      addr_hi,
   output logic [DATA_W-1:0]    led_out,
   output logic [DATA_W-1:0]    db_out,
   output logic                 db_oe
);

   // Elaboration-time parameter checks.
   generate
      if (ADDR_LO_W != 12) begin : g_bad_addr
         $error("trainer_bus_decoder: ADDR_LO_W must be 12");
      end
      if (HI_W < 1 || HI_W > DATA_W) begin : g_bad_hi
         $error("trainer_bus_decoder: HI_W must fit in the data bus");
      end
      if (RAM_BANKS < 2 || RAM_BANKS > 8 || (RAM_BANKS & (RAM_BANKS - 1)) != 0) begin : g_bad_banks
         $error("trainer_bus_decoder: RAM_BANKS must be 2, 4 or 8");
      end
   endgenerate

   logic              ram_rd;
   logic              sw_rd;
   logic              led_wr;
   logic              rom_rd;
   logic              addr_unused;

   // Offset bits inside a RAM bank or ROM are used by the arrays only.
   assign addr_unused = ^addr_lo[LOW_W-1:0];

   trainer_hi_latch #(
      .HI_W (HI_W)
   ) u_hi (
      .clk          (clk),
      .rst_n        (rst_n),
      .adr_strobe_n (adr_strobe_n),
      .db_hi        (db_in[DATA_W-1 -: HI_W]),
      .addr_hi      (addr_hi)
   );

   trainer_addr_decode #(
      .RAM_BANKS    (RAM_BANKS),
      .HI_W         (HI_W),
      .ZERO_PAGE_EN (ZERO_PAGE_EN)
   ) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_top  (addr_lo[ADDR_LO_W-1 -: TOP_W]),
      .addr_hi   (addr_hi),
      .rd_n      (rd_n),
      .wr_n      (wr_n),
      .rom_sel_n (rom_sel_n),
      .ram_sel_n (ram_sel_n),
      .ram_rd    (ram_rd),
      .sw_rd     (sw_rd),
      .led_wr    (led_wr)
   );

   assign rom_rd = ~&rom_sel_n;

   trainer_out_latch #(
      .DATA_W (DATA_W)
   ) u_led (
      .clk    (clk),
      .rst_n  (rst_n),
      .led_wr (led_wr),
      .din    (db_in),
      .led    (led_out)
   );

   trainer_rdata_mux #(
      .DATA_W (DATA_W)
   ) u_mux (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_n     (rd_n),
      .rom_rd   (rom_rd),
      .ram_rd   (ram_rd),
      .sw_rd    (sw_rd),
      .rom_data (rom_data),
      .ram_data (ram_data),
      .sw_in    (sw_in),
      .db_out   (db_out),
      .db_oe    (db_oe)
   );

endmodule

// File: tb/trainer_bus_decoder_tb.sv
`timescale 1ns/1ps
module trainer_bus_decoder_tb;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] addr_lo = '0;
   logic        adr_strobe_n = 1'b1;
   logic        rd_n = 1'b1;
   logic        wr_n = 1'b1;
   logic [7:0]  db_in = '0;
   logic [7:0]  sw_in = '0;
   logic [7:0]  rom_data = '0;
   logic [7:0]  ram_data = '0;

   logic [1:0]  zp_rom_sel_n, mr_rom_sel_n;
   logic [7:0]  zp_ram_sel_n, mr_ram_sel_n;
   logic [3:0]  zp_addr_hi, mr_addr_hi;
   logic [7:0]  zp_led, mr_led;
   logic [7:0]  zp_db, mr_db;
   logic        zp_oe, mr_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [3:0] hi_model = '0;
   logic [7:0] led_zp_model = '0;
   logic [7:0] led_mr_model = '0;

   always #(CLK_P/2) clk = ~clk;

   trainer_bus_decoder #(.ZERO_PAGE_EN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .addr_lo(addr_lo), .adr_strobe_n(adr_strobe_n),
      .rd_n(rd_n), .wr_n(wr_n), .db_in(db_in), .sw_in(sw_in),
      .rom_data(rom_data), .ram_data(ram_data),
      .rom_sel_n(zp_rom_sel_n), .ram_sel_n(zp_ram_sel_n), .addr_hi(zp_addr_hi),
      .led_out(zp_led), .db_out(zp_db), .db_oe(zp_oe));

   trainer_bus_decoder #(.ZERO_PAGE_EN(1'b0)) u_dut_mir (
      .clk(clk), .rst_n(rst_n), .addr_lo(addr_lo), .adr_strobe_n(adr_strobe_n),
      .rd_n(rd_n), .wr_n(wr_n), .db_in(db_in), .sw_in(sw_in),
      .rom_data(rom_data), .ram_data(ram_data),
      .rom_sel_n(mr_rom_sel_n), .ram_sel_n(mr_ram_sel_n), .addr_hi(mr_addr_hi),
      .led_out(mr_led), .db_out(mr_db), .db_oe(mr_oe));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h (addr=%h hi=%h rd_n=%b wr_n=%b)",
                  req, act, exp, addr_lo, hi_model, rd_n, wr_n);
      end
   endtask

   // Expected {rom_sel_n, ram_sel_n, db_oe, db_out}; mode 0 read, 1 write, 2 idle, 3 both low.
   function automatic logic [18:0] expect_bus(input bit zpe, input logic [3:0] hi,
                                              input logic [11:0] a, input int mode,
                                              input logic [7:0] rom, input logic [7:0] ram,
                                              input logic [7:0] sw);
      logic [1:0] rs = 2'b11;
      logic [7:0] bs = 8'hFF;
      logic       oe = 1'b0;
      logic [7:0] d  = 8'h00;
      bit ok = zpe ? (hi == 4'h0) : 1'b1;
      bit rd = (mode == 0);
      bit wr = (mode == 1);
      if (ok && rd) begin
         oe = 1'b1;
         if (a < 12'h800) begin
            rs[a[10]] = 1'b0;
            d = rom;
         end else if (a < 12'hC00) begin
            d = sw;
         end else begin
            d = ram;
         end
      end
      if (ok && (rd || wr) && a >= 12'hC00)
         bs[(a - 12'hC00) / 128] = 1'b0;
      return {rs, bs, oe, d};
   endfunction

   task automatic access(input logic [11:0] a, input int mode, input logic [7:0] data,
                         input logic strobe_n);
      logic [7:0] rom, ram, sw;
      rom = a[7:0] ^ 8'h5A;
      ram = ~a[7:0];
      sw  = {hi_model, a[3:0]} ^ 8'h3C;
      @(negedge clk);
      addr_lo = a; db_in = data; adr_strobe_n = strobe_n;
      rom_data = rom; ram_data = ram; sw_in = sw;
      rd_n = !(mode == 0 || mode == 3);
      wr_n = !(mode == 1 || mode == 3);
      #(CLK_P/4);
      // R2/R3/R4/R7/R8/R9 decode checks against both builds
      check("R2/R3/R4/R7/R8/R9 zero-page build", {13'b0, zp_rom_sel_n, zp_ram_sel_n, zp_oe, zp_db},
            {13'b0, expect_bus(1'b1, hi_model, a, mode, rom, ram, sw)});
      check("R2/R3/R4/R7/R8/R9 mirrored build", {13'b0, mr_rom_sel_n, mr_ram_sel_n, mr_oe, mr_db},
            {13'b0, expect_bus(1'b0, hi_model, a, mode, rom, ram, sw)});
      @(posedge clk);
      // R5/R10: the load is judged with the nibble held before this edge
      if (mode == 1 && a < 12'h800) begin
         if (hi_model == 4'h0) led_zp_model = data;
         led_mr_model = data;
      end
      if (!strobe_n) hi_model = data[7:4];
      #1;
      check("R5/R6 led zero-page", {24'b0, zp_led}, {24'b0, led_zp_model});
      check("R5/R6 led mirrored", {24'b0, mr_led}, {24'b0, led_mr_model});
      check("R1 high nibble", {24'b0, zp_addr_hi, mr_addr_hi}, {24'b0, hi_model, hi_model});
      @(negedge clk);
      rd_n = 1'b1; wr_n = 1'b1; adr_strobe_n = 1'b1;
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R6/R1: reset state
      check("R6 reset led", {16'b0, zp_led, mr_led}, 32'h0);
      check("R1 reset hi", {24'b0, zp_addr_hi, mr_addr_hi}, 32'h0);
      check("R8 reset selects idle", {22'b0, zp_rom_sel_n, zp_ram_sel_n}, {22'b0, 10'h3FF});
      @(negedge clk);
      rst_n = 1'b1;

      // Sweep every high nibble across all regions and strobe combinations.
      for (int h = 0; h < 16; h++) begin
         access(12'h000, 2, {4'(h), 4'h9}, 1'b0);
         for (int a = 0; a < 4096; a += 8) begin
            for (int m = 0; m < 4; m++) begin
               access(12'(a | (h & 7)), m, 8'(a + h * 17 + m), 1'b1);
            end
         end
      end

      // R10: strobe capture and LED write on the same edge.
      access(12'h000, 2, 8'h00, 1'b0);
      access(12'h123, 1, 8'hA7, 1'b0);
      check("R10 write landed with old nibble", {24'b0, zp_led}, 32'h0000_00A7);
      access(12'h124, 1, 8'h3C, 1'b1);
      check("R7 write ignored with new nibble", {24'b0, zp_led}, 32'h0000_00A7);
      check("R7 mirrored build took write", {24'b0, mr_led}, 32'h0000_003C);

      // R5: write into switch window changes nothing; R6: reads keep the register.
      access(12'h000, 2, 8'h05, 1'b0);
      access(12'h9F0, 1, 8'hEE, 1'b1);
      check("R5 switch-window write ignored", {16'b0, zp_led, mr_led}, 32'h0000_A73C);
      access(12'h010, 0, 8'h11, 1'b1);
      check("R6 read keeps led", {16'b0, zp_led, mr_led}, 32'h0000_A73C);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule